// File: doc/BRIEF.md
# Scan-chain to system-bus master bridge

This block lets a boundary-scan test port act as a master on a single-cycle-handshake memory bus with a 64-bit data path. A scan controller outside the block decodes the instruction register and presents the instruction code. It also presents the capture, shift and update strobes of the data-register path, all in the scan clock domain. Three instruction codes are recognised. One loads a target address. One starts a read at that address. One writes freshly shifted data while the same scan unloads the result of the previous access.

Each accepted update raises a request in the scan clock domain. The request crosses into the bus clock domain as a toggle through a synchroniser chain. The bus side runs exactly one classic cycle (cycle and strobe high, all byte lanes enabled) until the slave acknowledges. It then latches the access data and returns a completion toggle through a second synchroniser. The scan side refuses a new access until that completion arrives. A debugger therefore reads memory with an address scan followed by read scans. Each read scan collects the result of the scan before it.

Top module: `scan_bus_bridge`

## Requirements
- R1: With `rst` held high for at least three edges of each clock, the bus outputs `bus_cyc`, `bus_stb`, `bus_we` and `bus_sel` are all zero afterwards. The first address scan after reset unloads 0. The first data scan after reset unloads 0.
- R2: Instruction code 5 selects a 64-bit address register. Capture loads the stored address. Shifting moves the register one place towards bit 0 per scan clock, with `tdi` entering at bit 63 and `tdo` showing bit 0. Update stores the shifted value. An address scan therefore unloads the previous address.
- R3: Update under code 6 starts one bus cycle with `bus_we` = 0 at the stored address.
- R4: Update under code 7 starts one bus cycle with `bus_we` = 1 at the stored address, writing the 64 bits shifted in. The same scan unloads the data held from the previous access.
- R5: During a bus cycle, `bus_cyc` and `bus_stb` are high together and `bus_sel` is all ones. `bus_adr`, `bus_dat_w` and `bus_we` stay stable until `bus_ack`. Cycle and strobe drop on the clock after `bus_ack`.
- R6: The held data is updated on acknowledge: a read keeps `bus_dat_r`, a write keeps the written data. It is unloaded at the next capture under code 6 or 7.
- R7: The stored address does not advance after an access. Repeated accesses use the same address until an address update.
- R8: An update under code 6 or 7 that arrives before the previous access has completed is ignored and starts no bus cycle.
- R9: Under any other instruction code, `tdo` is 0. Update starts no bus cycle and leaves the stored address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| tck | input | 1 | Scan clock |
| ir | input | 4 | Current instruction code from the scan controller |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift enable for the selected data register |
| update_dr | input | 1 | Update strobe for the selected data register |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, bit 0 of the selected register |
| bus_adr | output | 64 | Bus byte address |
| bus_dat_w | output | 64 | Bus write data |
| bus_dat_r | input | 64 | Bus read data |
| bus_sel | output | 8 | Byte lane enables |
| bus_we | output | 1 | Write enable |
| bus_cyc | output | 1 | Cycle valid |
| bus_stb | output | 1 | Strobe |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
A wrong busy flag or a lost toggle shows at the ports within one access. Either a bus cycle never starts, which leaves the memory model unchanged, or a second cycle appears for an update that should have been ignored. A corrupt held-data register shows at the very next data scan as a wrong unloaded word. A wrong address register shows at the next address scan as a wrong unloaded address, and on the bus as a wrong `bus_adr` at the next access. Sweeping every word of a small memory with distinct computed patterns exposes a stuck or swapped bit within one scan.

// File: rtl/scan_bus_pkg.sv
`timescale 1ns/1ps
package scan_bus_pkg;
  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_ADDR,
    PATH_DATA
  } scan_path_e;
endpackage

// File: rtl/bb_toggle_sync.sv
`timescale 1ns/1ps
module bb_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tgl_i};
  end

  assign pulse_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/bb_scan_regs.sv
`timescale 1ns/1ps
module bb_scan_regs
  import scan_bus_pkg::*;
#(
  parameter int unsigned IR_W    = 4,
  parameter int unsigned AW      = 64,
  parameter int unsigned DW      = 64,
  parameter int unsigned OP_ADDR = 5,
  parameter int unsigned OP_READ = 6,
  parameter int unsigned OP_WRRD = 7
) (
  input  logic          tck,
  input  logic          rst,
  input  logic [IR_W-1:0] ir,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          tdi,
  output logic          tdo,
  input  logic [DW-1:0] rd_hold_i,
  input  logic          done_pulse_i,
  output logic          req_tgl_o,
  output logic          req_we_o,
  output logic [AW-1:0] req_adr_o,
  output logic [DW-1:0] req_dat_o
);
  scan_path_e    path;
  logic [AW-1:0] addr_sr, addr_reg;
  logic [DW-1:0] data_sr;
  logic          busy, launch, is_wr;

  always_comb begin
    if (ir == IR_W'(OP_ADDR))                              path = PATH_ADDR;
    else if (ir == IR_W'(OP_READ) || ir == IR_W'(OP_WRRD)) path = PATH_DATA;
    else                                                   path = PATH_NONE;
  end

  assign is_wr  = (ir == IR_W'(OP_WRRD));
  assign launch = update_dr && (path == PATH_DATA) && !busy;

  always_comb begin
    case (path)
      PATH_ADDR: tdo = addr_sr[0];
      PATH_DATA: tdo = data_sr[0];
      default:   tdo = 1'b0;
    endcase
  end

  // shift registers
  always_ff @(posedge tck) begin
    if (rst) begin
      addr_sr <= '0;
      data_sr <= '0;
    end else if (capture_dr) begin
      if (path == PATH_ADDR) addr_sr <= addr_reg;
      if (path == PATH_DATA) data_sr <= rd_hold_i;
    end else if (shift_dr) begin
      if (path == PATH_ADDR) addr_sr <= {tdi, addr_sr[AW-1:1]};
      if (path == PATH_DATA) data_sr <= {tdi, data_sr[DW-1:1]};
    end
  end

  // stored address
  always_ff @(posedge tck) begin
    if (rst)                                addr_reg <= '0;
    else if (update_dr && path == PATH_ADDR) addr_reg <= addr_sr;
  end

  // request launch and busy tracking
  always_ff @(posedge tck) begin
    if (rst) begin
      req_tgl_o <= 1'b0;
      req_we_o  <= 1'b0;
      req_adr_o <= '0;
      req_dat_o <= '0;
      busy      <= 1'b0;
    end else if (launch) begin
      req_tgl_o <= ~req_tgl_o;
      req_we_o  <= is_wr;
      req_adr_o <= addr_reg;
      if (is_wr) req_dat_o <= data_sr;
      busy      <= 1'b1;
    end else if (done_pulse_i) begin
      busy      <= 1'b0;
    end
  end

  a_r2_addr_only_on_update: assert property (@(posedge tck) disable iff (rst)
    !$stable(addr_reg) |-> $past(update_dr && ir == IR_W'(OP_ADDR)));

  a_r8_no_launch_while_busy: assert property (@(posedge tck) disable iff (rst)
    busy && !done_pulse_i |=> $stable(req_tgl_o) && $stable(req_adr_o) && $stable(req_dat_o));

  a_r9_tdo_quiet: assert property (@(posedge tck) disable iff (rst)
    path == PATH_NONE |-> !tdo);
endmodule

// File: rtl/bb_bus_master.sv
`timescale 1ns/1ps
module bb_bus_master #(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 64,
  localparam int unsigned SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_adr_i,
  input  logic [DW-1:0] req_dat_i,
  output logic          done_tgl_o,
  output logic [DW-1:0] rd_hold_o,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_w_o,
  input  logic [DW-1:0] dat_r_i,
  output logic [SW-1:0] sel_o,
  output logic          we_o,
  output logic          cyc_o,
  output logic          stb_o,
  input  logic          ack_i
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_o      <= 1'b0;
      stb_o      <= 1'b0;
      we_o       <= 1'b0;
      sel_o      <= '0;
      adr_o      <= '0;
      dat_w_o    <= '0;
      done_tgl_o <= 1'b0;
      rd_hold_o  <= '0;
    end else if (cyc_o) begin
      if (ack_i) begin
        cyc_o      <= 1'b0;
        stb_o      <= 1'b0;
        we_o       <= 1'b0;
        sel_o      <= '0;
        done_tgl_o <= ~done_tgl_o;
        rd_hold_o  <= we_o ? dat_w_o : dat_r_i;
      end
    end else if (go_i) begin
      cyc_o   <= 1'b1;
      stb_o   <= 1'b1;
      we_o    <= req_we_i;
      sel_o   <= '1;
      adr_o   <= req_adr_i;
      dat_w_o <= req_dat_i;
    end
  end

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    cyc_o && !ack_i |=> cyc_o && stb_o && $stable(adr_o) && $stable(we_o) && $stable(dat_w_o));

  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    cyc_o && ack_i |=> !cyc_o && !stb_o);

  a_r5_lanes_full: assert property (@(posedge clk) disable iff (rst)
    cyc_o |-> stb_o && (sel_o == {SW{1'b1}}));

  a_r6_done_on_ack: assert property (@(posedge clk) disable iff (rst)
    !$stable(done_tgl_o) |-> $past(cyc_o && ack_i));
endmodule

// File: rtl/scan_bus_bridge.sv
`timescale 1ns/1ps
module scan_bus_bridge #(
  parameter int unsigned IR_W     = 4,
  parameter int unsigned AW       = 64,
  parameter int unsigned DW       = 64,
  parameter int unsigned OP_ADDR  = 5,
  parameter int unsigned OP_READ  = 6,
  parameter int unsigned OP_WRRD  = 7,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned SW      = DW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tck,
  input  logic [IR_W-1:0] ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  output logic [AW-1:0]   bus_adr,
  output logic [DW-1:0]   bus_dat_w,
  input  logic [DW-1:0]   bus_dat_r,
  output logic [SW-1:0]   bus_sel,
  output logic            bus_we,
  output logic            bus_cyc,
  output logic            bus_stb,
  input  logic            bus_ack
);
  logic          req_tgl, req_we, go, done_tgl, done_pulse;
  logic [AW-1:0] req_adr;
  logic [DW-1:0] req_dat, rd_hold;

  bb_scan_regs #(
    .IR_W(IR_W), .AW(AW), .DW(DW),
    .OP_ADDR(OP_ADDR), .OP_READ(OP_READ), .OP_WRRD(OP_WRRD)
  ) u_scan (
    .tck(tck), .rst(rst), .ir(ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo),
    .rd_hold_i(rd_hold), .done_pulse_i(done_pulse),
    .req_tgl_o(req_tgl), .req_we_o(req_we), .req_adr_o(req_adr), .req_dat_o(req_dat)
  );

  bb_toggle_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(clk), .rst(rst), .tgl_i(req_tgl), .pulse_o(go)
  );

  bb_toggle_sync #(.STAGES(SYNC_STG)) u_done_sync (
    .clk(tck), .rst(rst), .tgl_i(done_tgl), .pulse_o(done_pulse)
  );

  bb_bus_master #(.AW(AW), .DW(DW)) u_master (
    .clk(clk), .rst(rst), .go_i(go),
    .req_we_i(req_we), .req_adr_i(req_adr), .req_dat_i(req_dat),
    .done_tgl_o(done_tgl), .rd_hold_o(rd_hold),
    .adr_o(bus_adr), .dat_w_o(bus_dat_w), .dat_r_i(bus_dat_r),
    .sel_o(bus_sel), .we_o(bus_we), .cyc_o(bus_cyc), .stb_o(bus_stb), .ack_i(bus_ack)
  );
endmodule

// File: tb/scan_bus_bridge_bench.sv
`timescale 1ns/1ps
module scan_bus_bridge_bench;
  logic        clk = 0, tck = 0, rst = 1;
  logic [3:0]  ir = 0;
  logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic        tdo;
  logic [63:0] bus_adr, bus_dat_w, bus_dat_r;
  logic [7:0]  bus_sel;
  logic        bus_we, bus_cyc, bus_stb, bus_ack;

  int checks = 0, failures = 0;
  int ack_delay = 2;
  int ack_cnt = 0;
  int n_wr = 0, n_rd = 0, proto_errs = 0;
  logic [63:0] last_adr = 0;
  logic        last_we = 0;
  logic        in_cyc = 0, ack_q = 0;
  logic [63:0] prev_adr = 0, prev_dat = 0;
  logic        prev_we = 0;
  logic [63:0] mem [16];
  longint      clk_cycles = 0;
  bit          done = 0;

  always #10 clk = ~clk;
  initial begin #7; forever #50 tck = ~tck; end

  scan_bus_bridge u_scan_bus_bridge (
    .clk(clk), .rst(rst), .tck(tck), .ir(ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo),
    .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_ack(bus_ack)
  );

  function automatic logic [63:0] init_word(int k);
    return 64'hC0DE_0000_0000_0000 + 64'(k) * 64'h0000_0101_0101_0101;
  endfunction

  function automatic logic [63:0] pattern(int k);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ 64'(k);
  endfunction

  // slave responder with programmable latency
  always @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 0;
      bus_dat_r <= 0;
      ack_cnt   <= 0;
    end else begin
      bus_ack <= 0;
      if (bus_cyc && bus_stb && !bus_ack) begin
        if (ack_cnt >= ack_delay) begin
          bus_ack   <= 1;
          ack_cnt   <= 0;
          bus_dat_r <= mem[bus_adr[6:3]];
          if (bus_we) begin
            mem[bus_adr[6:3]] <= bus_dat_w;
            n_wr <= n_wr + 1;
          end else begin
            n_rd <= n_rd + 1;
          end
          last_adr <= bus_adr;
          last_we  <= bus_we;
        end else begin
          ack_cnt <= ack_cnt + 1;
        end
      end
    end
  end

  // protocol monitor (R5)
  always @(posedge clk) begin
    if (!rst) begin
      if (bus_cyc && (!bus_stb || bus_sel !== 8'hFF)) proto_errs <= proto_errs + 1;
      if (in_cyc && bus_cyc && (bus_adr != prev_adr || bus_we != prev_we || bus_dat_w != prev_dat))
        proto_errs <= proto_errs + 1;
      if (ack_q && bus_cyc) proto_errs <= proto_errs + 1;
    end
    in_cyc   <= bus_cyc && !bus_ack;
    ack_q    <= bus_ack && bus_cyc;
    prev_adr <= bus_adr;
    prev_we  <= bus_we;
    prev_dat <= bus_dat_w;
  end

  // watchdog
  always @(posedge clk) begin
    clk_cycles <= clk_cycles + 1;
    if (clk_cycles > 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: actual=%0d expected<190000", clk_cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  task automatic scan(input logic [3:0] code, input logic [63:0] din, output logic [63:0] dout);
    @(negedge tck);
    ir = code;
    capture_dr = 1;
    @(negedge tck);
    capture_dr = 0;
    shift_dr = 1;
    for (int i = 0; i < 64; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      @(negedge tck);
    end
    shift_dr = 0;
    update_dr = 1;
    @(negedge tck);
    update_dr = 0;
  endtask

  logic [63:0] dout, exp_hold, exp_addr;
  int wr0, rd0;

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = init_word(k);
    idle(6);
    rst = 0;
    idle(2);

    // R1: reset state
    chk("R1 cyc", {63'd0, bus_cyc}, 64'd0);
    chk("R1 stb", {63'd0, bus_stb}, 64'd0);
    chk("R1 we", {63'd0, bus_we}, 64'd0);
    chk("R1 sel", {56'd0, bus_sel}, 64'd0);

    // R1/R2: first address scan unloads 0, second unloads the first
    scan(4'd5, 64'h18, dout);
    chk("R1 addr after reset", dout, 64'd0);
    scan(4'd5, 64'h18, dout);
    chk("R2 addr unload", dout, 64'h18);

    // R9: other code has no effect
    wr0 = n_wr; rd0 = n_rd;
    scan(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, dout);
    idle(12);
    chk("R9 tdo zero", dout, 64'd0);
    chk("R9 no cycle", 64'(n_wr + n_rd), 64'(wr0 + rd0));
    scan(4'd5, 64'h18, dout);
    chk("R9 addr kept", dout, 64'h18);

    // R3: read at 0x18, first data capture unloads 0 (R1)
    scan(4'd6, 64'd0, dout);
    idle(12);
    chk("R1 data after reset", dout, 64'd0);
    chk("R3 read addr", last_adr, 64'h18);
    chk("R3 read we", {63'd0, last_we}, 64'd0);
    chk("R3 read count", 64'(n_rd), 64'(rd0 + 1));

    // R4: write 0xfeef, unload read data
    scan(4'd7, 64'hfeef, dout);
    idle(12);
    chk("R4 unload previous read", dout, init_word(3));
    chk("R4 write we", {63'd0, last_we}, 64'd1);
    chk("R4 memory written", mem[3], 64'hfeef);

    // R6/R7: hold keeps written data, address unchanged
    scan(4'd6, 64'd0, dout);
    idle(12);
    chk("R6 hold after write", dout, 64'hfeef);
    chk("R7 addr after access", last_adr, 64'h18);
    scan(4'd6, 64'd0, dout);
    idle(12);
    chk("R6 read back", dout, 64'hfeef);
    chk("R7 addr repeated", last_adr, 64'h18);

    // sweep writes over all words (R2, R4, R6)
    exp_hold = 64'hfeef;
    exp_addr = 64'h18;
    for (int k = 0; k < 16; k++) begin
      scan(4'd5, 64'(k * 8), dout);
      chk("R2 sweep addr unload", dout, exp_addr);
      exp_addr = 64'(k * 8);
      scan(4'd7, pattern(k), dout);
      idle(12);
      chk("R4 sweep unload", dout, exp_hold);
      chk("R4 sweep memory", mem[k], pattern(k));
      chk("R4 sweep addr", last_adr, 64'(k * 8));
      exp_hold = pattern(k);
    end

    // sweep reads (R3, R6)
    for (int k = 15; k >= 0; k--) begin
      mem[k] = mem[k] ^ 64'(k + 1);
      scan(4'd5, 64'(k * 8), dout);
      scan(4'd6, 64'd0, dout);
      idle(12);
      chk("R6 sweep read unload", dout, exp_hold);
      chk("R3 sweep read addr", last_adr, 64'(k * 8));
      exp_hold = pattern(k) ^ 64'(k + 1);
    end
    scan(4'd6, 64'd0, dout);
    idle(12);
    chk("R6 final read unload", dout, exp_hold);

    // R8: update while busy is ignored
    ack_delay = 600;
    scan(4'd5, 64'h40, dout);
    wr0 = n_wr;
    scan(4'd7, 64'hAAAA_5555_1234_0001, dout);
    scan(4'd7, 64'hBBBB_6666_0000_0002, dout);
    idle(200);
    chk("R8 single write", 64'(n_wr), 64'(wr0 + 1));
    chk("R8 first data kept", mem[8], 64'hAAAA_5555_1234_0001);
    ack_delay = 2;
    scan(4'd6, 64'd0, dout);
    idle(12);
    chk("R8 hold from accepted write", dout, 64'hAAAA_5555_1234_0001);
    scan(4'd6, 64'd0, dout);
    idle(12);
    chk("R8 read back", dout, 64'hAAAA_5555_1234_0001);

    // R5: protocol monitor
    chk("R5 protocol errors", 64'(proto_errs), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule